// File: doc/BRIEF.md
# Processor Reset Stretcher with Configuration Strap Drive

This block turns an asynchronous, active-low platform reset into the reset that a host processor sees. The processor reset asserts at once when the platform reset asserts. After the platform reset releases, the processor reset stays asserted for a further interval of about one millisecond, counted in host clocks. A reset output that follows the input directly would give the processor no such settling time.

While the processor is held in reset, the block also drives a bus-request configuration strap low. The processor samples this strap when its reset releases. The strap is driven for the whole reset interval, so the setup before the release is met with margin. After the release the strap is held for a fixed, bounded number of clocks. The strap output-enable then drops so that the external line returns to high impedance. If the platform reset asserts again at any point, the sequence restarts from the beginning.

Top module: `proc_reset_seq`

## Requirements
- R1: Whenever `rstInN` is 0, `cpuRstN` is 0, and it falls with no wait for a clock edge. This includes the state after power-up.
- R2: After `rstInN` rises, `cpuRstN` stays 0 through the first `CLKS_PER_MS`+2 rising clock edges that follow. It becomes 1 just after edge number `CLKS_PER_MS`+3. That count is two synchroniser stages, one cycle to leave the reset state, and `CLKS_PER_MS` stretch cycles.
- R3: `strapDriveN` always carries the value 0, which is the low strap level. `strapOe` is 1 in every cycle in which `cpuRstN` is 0.
- R4: `strapOe` is 1 in each of the 4 or more clock cycles before `cpuRstN` rises. `CLKS_PER_MS` below 4 is rejected at elaboration.
- R5: After `cpuRstN` rises, `strapOe` stays 1 for exactly `HOLD_CLKS` cycles and then falls to 0, which tri-states the strap. `HOLD_CLKS` outside 2 to 20 is rejected at elaboration, and its default is 4.
- R6: Once the sequence has completed, `cpuRstN`=1 and `strapOe`=0 hold for as long as `rstInN` stays 1.
- R7: If `rstInN` falls during the stretch, during the strap hold or while running, the outputs return at once to `cpuRstN`=0 and `strapOe`=1. The next release then replays the full timing of R2 and R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rstInN | input | 1 | Asynchronous platform reset, active low |
| cpuRstN | output | 1 | Processor reset, active low |
| strapDriveN | output | 1 | Value to place on the strap line while enabled (always low) |
| strapOe | output | 1 | Strap output-enable; 0 leaves the line at high impedance |

## Verification
The bench builds the block with `CLKS_PER_MS`=12 and `HOLD_CLKS`=5. With these values a complete stretch and hold take only about twenty clocks. Many randomised releases and re-assertions therefore fit into a short run and reach every phase, including the cycles at the edges of the stretch and the hold. A hold of 5 is not the default value. This shows that the hold length follows the parameter rather than a fixed count.

// File: rtl/proc_reset_pkg.sv
package proc_reset_pkg;
  typedef enum logic [1:0] {
    ST_RESET   = 2'd0,
    ST_STRETCH = 2'd1,
    ST_HOLD    = 2'd2,
    ST_RUN     = 2'd3
  } seqState_t;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } cntCmd_t;
endpackage

// File: rtl/proc_reset_sync.sv
module proc_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstInN,
  output logic syncRstN
);
  if (STAGES < 2) begin : g_badStages
    $error("proc_reset_sync: STAGES must be at least 2");
  end

  logic [STAGES-1:0] pipe;

  // Assertion clears at once; release ripples through the flops
  always_ff @(posedge clk or negedge rstInN) begin
    if (!rstInN) pipe <= '0;
    else         pipe <= {pipe[STAGES-2:0], 1'b1};
  end

  assign syncRstN = pipe[STAGES-1];
endmodule

// File: rtl/proc_reset_dp.sv
module proc_reset_dp
  import proc_reset_pkg::*;
#(
  parameter int CLKS_PER_MS = 100000,
  parameter int HOLD_CLKS   = 4
) (
  input  logic    clk,
  input  logic    syncRstN,
  input  cntCmd_t cmd,
  output logic    stretchEnd,
  output logic    holdEnd
);
  localparam int CNT_LIMIT = (CLKS_PER_MS > HOLD_CLKS) ? CLKS_PER_MS : HOLD_CLKS;
  localparam int CNT_W     = $clog2(CNT_LIMIT + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge syncRstN) begin
    if (!syncRstN)       cnt <= '0;
    else if (cmd.cntClr) cnt <= '0;
    else if (cmd.cntInc) cnt <= cnt + 1'b1;
  end

  assign stretchEnd = (cnt == CNT_W'(CLKS_PER_MS - 1));
  assign holdEnd    = (cnt == CNT_W'(HOLD_CLKS - 1));

  // R2: the shared counter never runs past the longer of the two windows
  p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!syncRstN)
    cnt < CNT_W'(CNT_LIMIT));
endmodule

// File: rtl/proc_reset_ctrl.sv
module proc_reset_ctrl
  import proc_reset_pkg::*;
(
  input  logic    clk,
  input  logic    syncRstN,
  input  logic    stretchEnd,
  input  logic    holdEnd,
  output cntCmd_t cmd,
  output logic    cpuRstN,
  output logic    strapDriveN,
  output logic    strapOe
);
  seqState_t state, stateNext;

  always_ff @(posedge clk or negedge syncRstN) begin
    if (!syncRstN) state <= ST_RESET;
    else           state <= stateNext;
  end

  always_comb begin
    stateNext  = state;
    cmd.cntClr = 1'b0;
    cmd.cntInc = 1'b0;
    case (state)
      ST_RESET: begin
        stateNext  = ST_STRETCH;
        cmd.cntClr = 1'b1;
      end
      ST_STRETCH: begin
        if (stretchEnd) begin
          stateNext  = ST_HOLD;
          cmd.cntClr = 1'b1;
        end else begin
          cmd.cntInc = 1'b1;
        end
      end
      ST_HOLD: begin
        if (holdEnd) begin
          stateNext  = ST_RUN;
          cmd.cntClr = 1'b1;
        end else begin
          cmd.cntInc = 1'b1;
        end
      end
      default: stateNext = ST_RUN;
    endcase
  end

  assign cpuRstN     = (state == ST_HOLD) || (state == ST_RUN);
  assign strapOe     = (state != ST_RUN);
  assign strapDriveN = 1'b0;

  // R2: processor reset releases only at the end of a full stretch count
  p_release_after_stretch_r2: assert property (@(posedge clk) disable iff (!syncRstN)
    $rose(cpuRstN) |-> $past(stretchEnd));

  // R4: strap was enabled during the cycles leading up to the release
  p_strap_setup_r4: assert property (@(posedge clk) disable iff (!syncRstN)
    $rose(cpuRstN) |-> ($past(strapOe, 1) && $past(strapOe, 4)));

  // R5: strap is released only after the processor reset has been high for a while
  p_hold_min_r5: assert property (@(posedge clk) disable iff (!syncRstN)
    $fell(strapOe) |-> ($past(cpuRstN, 1) && $past(cpuRstN, 2)));

  // R6: running state is kept until the next reset
  p_run_sticky_r6: assert property (@(posedge clk) disable iff (!syncRstN)
    (state == ST_RUN) |=> (state == ST_RUN));
endmodule

// File: rtl/proc_reset_seq.sv
module proc_reset_seq
  import proc_reset_pkg::*;
#(
  parameter int CLKS_PER_MS = 100000,
  parameter int HOLD_CLKS   = 4
) (
  input  logic clk,
  input  logic rstInN,
  output logic cpuRstN,
  output logic strapDriveN,
  output logic strapOe
);
  if (CLKS_PER_MS < 4) begin : g_badStretch
    $error("proc_reset_seq: CLKS_PER_MS must be at least 4 for strap setup");
  end
  if (HOLD_CLKS < 2 || HOLD_CLKS > 20) begin : g_badHold
    $error("proc_reset_seq: HOLD_CLKS must lie in 2..20");
  end

  logic    syncRstN;
  logic    stretchEnd;
  logic    holdEnd;
  cntCmd_t cmd;

  proc_reset_sync #(.STAGES(2)) u_sync (
    .clk      (clk),
    .rstInN   (rstInN),
    .syncRstN (syncRstN)
  );

  proc_reset_dp #(.CLKS_PER_MS(CLKS_PER_MS), .HOLD_CLKS(HOLD_CLKS)) u_dp (
    .clk        (clk),
    .syncRstN   (syncRstN),
    .cmd        (cmd),
    .stretchEnd (stretchEnd),
    .holdEnd    (holdEnd)
  );

  proc_reset_ctrl u_ctrl (
    .clk         (clk),
    .syncRstN    (syncRstN),
    .stretchEnd  (stretchEnd),
    .holdEnd     (holdEnd),
    .cmd         (cmd),
    .cpuRstN     (cpuRstN),
    .strapDriveN (strapDriveN),
    .strapOe     (strapOe)
  );

  // R1: platform reset low forces processor reset low
  p_follow_input_r1: assert property (@(posedge clk)
    !rstInN |-> !cpuRstN);
endmodule

// File: tb/sim_proc_reset_seq.sv
module sim_proc_reset_seq;
  localparam int N = 12;
  localparam int H = 5;
  localparam int REL_EDGE = N + 3;

  logic clk = 1'b0;
  logic rstInN = 1'b0;
  logic cpuRstN, strapDriveN, strapOe;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  proc_reset_seq #(.CLKS_PER_MS(N), .HOLD_CLKS(H)) u0 (
    .clk(clk), .rstInN(rstInN), .cpuRstN(cpuRstN),
    .strapDriveN(strapDriveN), .strapOe(strapOe)
  );

  function automatic logic expRst(int k);
    return (k >= REL_EDGE);
  endfunction

  function automatic logic expOe(int k);
    return (k < REL_EDGE + H);
  endfunction

  task automatic check(string req, logic act, logic exp, int k);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s edge=%0d actual=%0b expected=%0b", req, k, act, exp);
    end
  endtask

  // Hold reset low for a few cycles; outputs must show full reset (R1, R3)
  task automatic holdReset(int cycles);
    @(negedge clk);
    rstInN = 1'b0;
    #1;
    check("R1", cpuRstN, 1'b0, -1);
    check("R3", strapOe, 1'b1, -1);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check("R1", cpuRstN, 1'b0, -1);
      check("R3", strapOe, 1'b1, -1);
      check("R3", strapDriveN, 1'b0, -1);
    end
  endtask

  // Release and follow for len edges, then reassert (R7)
  task automatic runRelease(int len);
    string tag;
    rstInN = 1'b1;
    for (int k = 1; k <= len; k++) begin
      @(posedge clk);
      @(negedge clk);
      check("R2", cpuRstN, expRst(k), k);
      if (k < REL_EDGE)          tag = "R4";
      else if (k < REL_EDGE + H) tag = "R5";
      else                       tag = "R6";
      check(tag, strapOe, expOe(k), k);
      if (!cpuRstN) check("R3", strapOe, 1'b1, k);
    end
    rstInN = 1'b0;
    #1;
    check("R7", cpuRstN, 1'b0, len);
    check("R7", strapOe, 1'b1, len);
  endtask

  initial begin
    #1;
    check("R1", cpuRstN, 1'b0, 0);
    check("R3", strapOe, 1'b1, 0);
    check("R3", strapDriveN, 1'b0, 0);
    holdReset(3);
    // directed: full run and long idle, then phase-edge reassertions
    runRelease(REL_EDGE + H + 30);
    holdReset(2);
    runRelease(REL_EDGE);
    holdReset(1);
    runRelease(REL_EDGE - 1);
    holdReset(1);
    runRelease(REL_EDGE + H - 1);
    holdReset(1);
    runRelease(REL_EDGE + H);
    holdReset(1);
    runRelease(1);
    holdReset(1);
    void'($urandom(32'd1234));
    for (int t = 0; t < 60; t++) begin
      holdReset(1 + int'($urandom_range(0, 4)));
      @(negedge clk);
      runRelease(1 + int'($urandom_range(0, REL_EDGE + H + 8)));
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule